// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the physical-layer engine of a two-wire serial link in which a host controller runs the protocol through register writes. It holds an 8-bit shift register and a 4-bit edge counter. It also has open-drain controls for the clock line (SCL) and the data line (SDA). In either role, shifting and counting run in hardware on every SCL transition the block sees. When the counter wraps, it sets a completion flag that the host polls. The host carries all protocol decisions: addressing, acknowledge handling and transfer direction.

In master role, the block never runs a clock of its own. The host toggles a clock-output register, and the block reports whether a released SCL is still being held low by another device. In slave role, a hold unit pulls SCL low to insert wait states. It does this after a start condition, or after the counter wraps at the end of a transfer, and keeps it up until the host clears the flag.

Each line is modelled as a drive-low enable plus a sampled input. A released line reads high through an external pull-up. The inputs are used as sampled, with no synchronising or filtering stage.

Top module: `twShifter`

## Requirements
- R1: After reset, both drive-low outputs are 0, the shift register and the counter are 0, both flags are 0, and the stretch status is 0.
- R2: In master role, a host write to address 2 with bit 2 set toggles the SCL drive. The first toggle after reset drives SCL low and the next one releases it. In slave role the same write has no effect, including on the clock state seen after returning to master role.
- R3: Every SCL transition (a change of the sampled sclIn from one clock to the next) adds 1 to the 4-bit counter, modulo 16. The new count is visible one clock later.
- R4: On every SCL falling edge, the shift register moves one place toward the MSB. Bit 0 takes the SDA value sampled at the most recent SCL rising edge. After eight rise/fall pairs that start with SCL low, the register holds the received byte, MSB first.
- R5: sdaDrvLow is 1 exactly when the data-output enable (address 3, bit 0) is 1 and the shift register MSB is 0.
- R6: An edge that moves the counter from 15 to 0 sets ovfFlag. A write to address 2 with bit 0 set clears it. A write to address 1 preloads the counter from bits 3:0, so a preload of 14 overflows after two edges.
- R7: SDA falling while SCL is high on two consecutive samples sets startFlag. A write to address 2 with bit 1 set clears it.
- R8: In slave role, while ovfFlag or startFlag is set and SCL reads low, sclDrvLow goes to 1 within one clock. It stays 1 until both flags are clear and drops the clock after that. It never asserts while SCL stays high.
- R9: In master role, the flags never cause sclDrvLow. SCL is driven only by the clock-output register.
- R10: In master role, stretchSeen is 1 while the block releases SCL but sclIn reads low.
- R11: A host write to address 0 (data load) or address 1 (counter preload) takes priority over a shift or count in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slaveRole | input | 1 | 1 selects slave role, 0 selects master role |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 2 | Host register address: 0 data, 1 counter, 2 command, 3 config |
| hostWrData | input | 8 | Host write data |
| shiftData | output | 8 | Shift register contents |
| edgeCount | output | 4 | Edge counter value |
| ovfFlag | output | 1 | Counter-wrap (transfer complete) flag |
| startFlag | output | 1 | Start condition detected flag |
| stretchSeen | output | 1 | Master released SCL but the line reads low |

## Verification
The bench loops a master transmit back through its own SDA sampling. A design that samples on the wrong edge, or shifts the new bit in without the one-edge delay, returns a corrupted byte. Preloading 14 and wrapping the counter exposes an off-by-one overflow compare, which would raise the flag one edge early or late. Hold tests check three things: that a set flag does not pull SCL while it is high, that the hold outlives the slave side releasing SCL, and that master role ignores the flags. A design that let the toggle act in slave role, or let a shift beat a same-cycle data load, shows the wrong clock state or the wrong byte at the ports.

// File: rtl/twShiftPkg.sv
package twShiftPkg;

  // host register map
  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CMD   = 2'd2;
  localparam logic [1:0] ADDR_CFG   = 2'd3;

  // command register bit positions
  localparam int CMD_CLR_OVF   = 0;
  localparam int CMD_CLR_START = 1;
  localparam int CMD_TOGGLE    = 2;

  // config register bit positions
  localparam int CFG_SDA_EN = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadCount;
    logic countEdge;
    logic shiftNow;
    logic sampleNow;
  } twStrobe_t;

endpackage

// File: rtl/twShiftData.sv
module twShiftData
  import twShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  twStrobe_t         st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  count,
  output logic              countAtMax,
  output logic              msb
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sdaLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaLatch <= 1'b1;
      shiftReg <= '0;
      count    <= '0;
    end else begin
      if (st.sampleNow) sdaLatch <= sdaIn;

      if (st.loadData)      shiftReg <= wrData;
      else if (st.shiftNow) shiftReg <= {shiftReg[DATA_W-2:0], sdaLatch};

      if (st.loadCount)      count <= wrData[CNT_W-1:0];
      else if (st.countEdge) count <= count + 1'b1;
    end
  end

  assign countAtMax = (count == CNT_MAX);
  assign msb        = shiftReg[DATA_W-1];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.countEdge && !st.loadCount |=> count == CNT_W'($past(count) + 1'b1)); // R3

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftNow && !st.loadData |=> shiftReg[0] == $past(sdaLatch)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    st.loadData |=> shiftReg == $past(wrData)); // R11

endmodule

// File: rtl/twShiftCtrl.sv
module twShiftCtrl
  import twShiftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveRole,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              countAtMax,
  output twStrobe_t         st,
  output logic              sclDrvLow,
  output logic              sdaOutEn,
  output logic              ovfFlag,
  output logic              startFlag,
  output logic              stretchSeen
);

  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen;
  logic wrCmd, wrCfg;
  logic sclHigh;
  logic holdActive;
  logic wrapNow;

  // edge and condition detection on the raw sampled lines
  assign sclRise   = sclIn & ~sclPrev;
  assign sclFall   = ~sclIn & sclPrev;
  assign startSeen = sclIn & sclPrev & sdaPrev & ~sdaIn;

  // host decode
  assign wrCmd = hostWrEn && (hostAddr == ADDR_CMD);
  assign wrCfg = hostWrEn && (hostAddr == ADDR_CFG);

  always_comb begin
    st.loadData  = hostWrEn && (hostAddr == ADDR_DATA);
    st.loadCount = hostWrEn && (hostAddr == ADDR_COUNT);
    st.countEdge = sclRise | sclFall;
    st.shiftNow  = sclFall;
    st.sampleNow = sclRise;
  end

  assign wrapNow = st.countEdge && countAtMax && !st.loadCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      ovfFlag    <= 1'b0;
      startFlag  <= 1'b0;
      sclHigh    <= 1'b1;
      sdaOutEn   <= 1'b0;
      holdActive <= 1'b0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;

      if (wrapNow)                               ovfFlag <= 1'b1;
      else if (wrCmd && hostWrData[CMD_CLR_OVF]) ovfFlag <= 1'b0;

      if (startSeen)                               startFlag <= 1'b1;
      else if (wrCmd && hostWrData[CMD_CLR_START]) startFlag <= 1'b0;

      if (wrCmd && hostWrData[CMD_TOGGLE] && !slaveRole) sclHigh <= ~sclHigh;

      if (wrCfg) sdaOutEn <= hostWrData[CFG_SDA_EN];

      holdActive <= slaveRole && (ovfFlag || startFlag) && (holdActive || !sclIn);
    end
  end

  assign sclDrvLow   = slaveRole ? holdActive : ~sclHigh;
  assign stretchSeen = ~slaveRole & sclHigh & ~sclIn;

  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(countAtMax && st.countEdge)); // R6

  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startFlag) |-> $past(sclIn && !sdaIn)); // R7

  AST_SLAVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    slaveRole && ovfFlag && !sclIn |=> sclDrvLow || !slaveRole); // R8

  AST_MASTER_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slaveRole |=> !holdActive); // R9

endmodule

// File: rtl/twShifter.sv
module twShifter
  import twShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveRole,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] shiftData,
  output logic [CNT_W-1:0]  edgeCount,
  output logic              ovfFlag,
  output logic              startFlag,
  output logic              stretchSeen
);

  twStrobe_t st;
  logic countAtMax;
  logic msb;
  logic sdaOutEn;

  twShiftCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slaveRole  (slaveRole),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .countAtMax (countAtMax),
    .st         (st),
    .sclDrvLow  (sclDrvLow),
    .sdaOutEn   (sdaOutEn),
    .ovfFlag    (ovfFlag),
    .startFlag  (startFlag),
    .stretchSeen(stretchSeen)
  );

  twShiftData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wrData    (hostWrData),
    .sdaIn     (sdaIn),
    .shiftReg  (shiftData),
    .count     (edgeCount),
    .countAtMax(countAtMax),
    .msb       (msb)
  );

  assign sdaDrvLow = sdaOutEn & ~msb;

endmodule

// File: tb/twShifter_tb.sv
module twShifter_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveRole = 1'b0;
  logic tbSclLow = 1'b0;
  logic tbSdaLow = 1'b0;
  logic hostWrEn = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'd0;

  logic sclDrvLow, sdaDrvLow, ovfFlag, startFlag, stretchSeen;
  logic [7:0] shiftData;
  logic [3:0] edgeCount;
  logic sclLine, sdaLine;

  int checks = 0;
  int failures = 0;

  assign sclLine = ~(sclDrvLow | tbSclLow);
  assign sdaLine = ~(sdaDrvLow | tbSdaLow);

  always #5 clk = ~clk;

  twShifter u_dut (
    .clk(clk), .rstN(rstN), .slaveRole(slaveRole),
    .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .shiftData(shiftData), .edgeCount(edgeCount),
    .ovfFlag(ovfFlag), .startFlag(startFlag), .stretchSeen(stretchSeen)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic toggleScl();
    hostWrite(2'd2, 8'h04);
    idle(1);
  endtask

  task automatic sclEdge(input logic low);
    @(negedge clk);
    tbSclLow = low;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 sclDrvLow", sclDrvLow, 0);
    check("R1 sdaDrvLow", sdaDrvLow, 0);
    check("R1 count", edgeCount, 0);
    check("R1 data", shiftData, 0);
    check("R1 ovf", ovfFlag, 0);
    check("R1 start", startFlag, 0);
    check("R1 stretch", stretchSeen, 0);
  endtask

  task automatic t_master_toggle();
    slaveRole = 1'b0;
    toggleScl();
    check("R2 toggle drives low", sclDrvLow, 1);
    check("R3 fall counted", edgeCount, 1);
    toggleScl();
    check("R2 toggle releases", sclDrvLow, 0);
    check("R3 rise counted", edgeCount, 2);
    tbSclLow = 1'b1; idle(1);
    check("R10 stretch seen", stretchSeen, 1);
    tbSclLow = 1'b0; idle(1);
    check("R10 stretch gone", stretchSeen, 0);
  endtask

  task automatic t_master_tx();
    logic [7:0] tx = 8'hA5;
    hostWrite(2'd2, 8'h03);
    toggleScl();
    hostWrite(2'd1, 8'h00);
    hostWrite(2'd0, tx);
    hostWrite(2'd3, 8'h01);
    for (int i = 7; i >= 0; i--) begin
      check("R5 sda drive", sdaDrvLow, {31'd0, ~tx[i]});
      toggleScl();
      toggleScl();
      check("R3 tx count", edgeCount, (2 * (8 - i)) % 16);
    end
    check("R4 loopback byte", shiftData, tx);
    check("R6 ovf after 16 edges", ovfFlag, 1);
    hostWrite(2'd3, 8'h00);
    toggleScl();
    hostWrite(2'd2, 8'h03);
    check("R5 sda released", sdaDrvLow, 0);
  endtask

  task automatic t_slave_rx();
    logic [7:0] rx = 8'h3C;
    slaveRole = 1'b1;
    tbSclLow = 1'b1; idle(1);
    hostWrite(2'd2, 8'h03);
    hostWrite(2'd1, 8'h00);
    hostWrite(2'd0, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      tbSdaLow = ~rx[i];
      sclEdge(1'b0);
      sclEdge(1'b1);
    end
    check("R4 received byte", shiftData, rx);
    check("R6 ovf on wrap", ovfFlag, 1);
    idle(2);
    check("R8 hold after ovf", sclDrvLow, 1);
    tbSclLow = 1'b0; idle(2);
    check("R8 line held low", sclLine, 0);
    tbSdaLow = 1'b0;
    hostWrite(2'd2, 8'h01);
    idle(2);
    check("R8 hold released", sclDrvLow, 0);
  endtask

  task automatic t_preload();
    hostWrite(2'd1, 8'h0E);
    sclEdge(1'b1);
    check("R6 no ovf at 15", ovfFlag, 0);
    check("R6 count 15", edgeCount, 15);
    sclEdge(1'b0);
    check("R6 ovf after preload", ovfFlag, 1);
    check("R6 count wrapped", edgeCount, 0);
    idle(2);
    check("R8 no hold while scl high", sclDrvLow, 0);
    hostWrite(2'd2, 8'h01);
    check("R6 ovf cleared", ovfFlag, 0);
  endtask

  task automatic t_start();
    tbSdaLow = 1'b1; idle(1);
    check("R7 start detected", startFlag, 1);
    idle(2);
    check("R8 no hold with scl high", sclDrvLow, 0);
    tbSclLow = 1'b1; idle(3);
    check("R8 hold after start", sclDrvLow, 1);
    tbSdaLow = 1'b0;
    tbSclLow = 1'b0; idle(1);
    check("R8 scl held after start", sclLine, 0);
    hostWrite(2'd2, 8'h02);
    idle(2);
    check("R7 start cleared", startFlag, 0);
    check("R8 start hold released", sclDrvLow, 0);
  endtask

  task automatic t_slave_toggle();
    hostWrite(2'd2, 8'h04);
    idle(2);
    check("R2 slave toggle ignored", sclDrvLow, 0);
    slaveRole = 1'b0; idle(1);
    check("R2 clock state untouched", sclDrvLow, 0);
  endtask

  task automatic t_master_nohold();
    slaveRole = 1'b0;
    tbSdaLow = 1'b1; idle(2);
    check("R7 master start flag", startFlag, 1);
    tbSclLow = 1'b1; idle(3);
    check("R9 master never holds", sclDrvLow, 0);
    tbSclLow = 1'b0; idle(1);
    tbSdaLow = 1'b0; idle(1);
    hostWrite(2'd2, 8'h02);
  endtask

  task automatic t_priority();
    @(negedge clk);
    tbSclLow = 1'b1;
    hostWrEn = 1'b1; hostAddr = 2'd1; hostWrData = 8'h05;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R11 preload beats count", edgeCount, 5);
    tbSclLow = 1'b0; idle(1);
    check("R3 count after rise", edgeCount, 6);
    @(negedge clk);
    tbSclLow = 1'b1;
    hostWrEn = 1'b1; hostAddr = 2'd0; hostWrData = 8'h81;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R11 load beats shift", shiftData, 8'h81);
    check("R3 count after fall", edgeCount, 7);
    tbSclLow = 1'b0; idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_master_toggle();
    t_master_tx();
    t_slave_rx();
    t_preload();
    t_start();
    t_slave_toggle();
    t_master_nohold();
    t_priority();
    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule